// File: doc/BRIEF.md
# Timer Input Capture Unit

This block samples a free-running 16-bit timer at the moment a chosen event arrives on an asynchronous input pin. A select bit picks one of two external timers as the source. The pin is synchronized and edge-detected on chip. A 4-bit mode field picks the qualifying event: a falling edge, a rising edge, or every 4th or every 16th rising edge. Each qualifying event copies the selected timer into the capture register in a single cycle and raises a sticky interrupt flag. Software later clears the flag with a one-cycle strobe.

The rising-edge prescaler counter is cleared only when the unit is off or capture is disabled. Moving directly between two capture codes keeps the count and raises the flag without a capture. The safe way to change the prescale ratio is to pass through the off code first.

Top module: `capt_unit`

## Requirements
- R1: The pin passes through two synchronizer flops and an edge detector. A pin change made before clock edge 1 loads the capture register on clock edge 3, and not earlier.
- R2: Mode codes are 0000 = off, 0100 = falling edge, 0101 = rising edge, 0110 = every 4th rising edge, 0111 = every 16th rising edge. Every other code disables capture: the capture register and the flag are left unchanged.
- R3: A capture copies timerA when timerSel is 0, and timerB when timerSel is 1. The value copied is the one present at the capturing clock edge.
- R4: Every capture sets capFlag.
- R5: capFlag stays set until flagClr is high at a clock edge with no set in that same cycle; it then reads 0 after that edge.
- R6: When a set and flagClr occur in the same cycle, the set wins.
- R7: A new capture replaces the capture register even if the flag is still set.
- R8: A 4-bit prescaler counter advances on every synchronized rising edge while a capture code (01xx) is active. In mode 0110 a capture happens on the rising edge whose prior count has low two bits 11. In mode 0111 it happens on the rising edge whose prior count is 1111.
- R9: The prescaler counter clears whenever the mode is not a capture code (off or disabled), and on reset.
- R10: Changing directly from one capture code to a different capture code keeps the counter, so the first prescaled capture may come early. The change also sets capFlag one cycle later without loading the capture register.
- R11: Entering a capture code from off or from a disabled code does not set capFlag.
- R12: After reset, capValue is 0 and capFlag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 4 | Event/mode select code |
| capPin | input | 1 | Asynchronous capture input pin |
| timerA | input | 16 | First timer source |
| timerB | input | 16 | Second timer source |
| timerSel | input | 1 | Timer source select (0 = timerA, 1 = timerB) |
| flagClr | input | 1 | Software flag-clear strobe |
| capValue | output | 16 | Captured timer value |
| capFlag | output | 1 | Sticky capture interrupt flag |

## Verification
The bench builds the unit with its default parameters: a 16-bit timer, a 4-bit prescaler and two synchronizer stages. At this size all sixteen mode codes can be swept. Each code gets eighteen rising and falling pin pulses, so the 16-count wrap is crossed at least once in every code and the expected capture points follow from pulse index modulo ratio. The small prescaler also keeps the early-capture case after a direct ratio change within a few pulses, alongside the clear-through-off sequence.

// File: rtl/capt_pkg.sv
package capt_pkg;
  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MODE_OFF   = 4'b0000;
  localparam logic [MODE_W-1:0] MODE_FALL  = 4'b0100;
  localparam logic [MODE_W-1:0] MODE_RISE  = 4'b0101;
  localparam logic [MODE_W-1:0] MODE_DIV4  = 4'b0110;
  localparam logic [MODE_W-1:0] MODE_DIV16 = 4'b0111;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCap;
    logic setFlag;
  } capStrobes_t;

  function automatic logic isCapture(input logic [MODE_W-1:0] m);
    return m[3:2] == 2'b01;
  endfunction
endpackage

// File: rtl/capt_datapath.sv
module capt_datapath
  import capt_pkg::*;
#(
  parameter int TIMER_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               capPin,
  input  logic [TIMER_W-1:0] timerA,
  input  logic [TIMER_W-1:0] timerB,
  input  logic               timerSel,
  input  logic               flagClr,
  input  capStrobes_t        strb,
  output logic               riseEv,
  output logic               fallEv,
  output logic [TIMER_W-1:0] capValue,
  output logic               capFlag
);
  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   pinPrev;
  logic [TIMER_W-1:0]     timerMux;

  // synchronizer chain, depth picked by parameter
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= capPin;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], capPin};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) pinPrev <= 1'b0;
    else       pinPrev <= syncQ[SYNC_MSB];

  assign riseEv = syncQ[SYNC_MSB] & ~pinPrev;
  assign fallEv = ~syncQ[SYNC_MSB] & pinPrev;

  assign timerMux = timerSel ? timerB : timerA;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)             capValue <= '0;
    else if (strb.loadCap) capValue <= timerMux;

  // set has priority over clear
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)             capFlag <= 1'b0;
    else if (strb.setFlag) capFlag <= 1'b1;
    else if (flagClr)      capFlag <= 1'b0;
endmodule

// File: rtl/capt_control.sv
module capt_control
  import capt_pkg::*;
#(
  parameter int PS_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] mode,
  input  logic              riseEv,
  input  logic              fallEv,
  output capStrobes_t       strb
);
  logic [PS_W-1:0]   psCnt;
  logic [MODE_W-1:0] modePrev;
  logic              enNow;
  logic              evHit;
  logic              modeSwap;

  assign enNow = isCapture(mode);

  // counter only cleared by off/disabled, not by ratio change
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)       psCnt <= '0;
    else if (!enNow) psCnt <= '0;
    else if (riseEv) psCnt <= psCnt + 1'b1;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) modePrev <= MODE_OFF;
    else       modePrev <= mode;

  always_comb begin
    case (mode)
      MODE_FALL:  evHit = fallEv;
      MODE_RISE:  evHit = riseEv;
      MODE_DIV4:  evHit = riseEv & (&psCnt[1:0]);
      MODE_DIV16: evHit = riseEv & (&psCnt[3:0]);
      default:    evHit = 1'b0;
    endcase
  end

  assign modeSwap = enNow & isCapture(modePrev) & (mode != modePrev);

  assign strb.loadCap = evHit;
  assign strb.setFlag = evHit | modeSwap;
endmodule

// File: rtl/capt_unit.sv
module capt_unit
  import capt_pkg::*;
#(
  parameter int TIMER_W     = 16,
  parameter int PS_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [3:0]         mode,
  input  logic               capPin,
  input  logic [TIMER_W-1:0] timerA,
  input  logic [TIMER_W-1:0] timerB,
  input  logic               timerSel,
  input  logic               flagClr,
  output logic [TIMER_W-1:0] capValue,
  output logic               capFlag
);
  capStrobes_t strb;
  logic        riseEv;
  logic        fallEv;

  capt_control #(.PS_W(PS_W)) u_ctl (
    .clk(clk), .rstN(rstN), .mode(mode),
    .riseEv(riseEv), .fallEv(fallEv), .strb(strb)
  );

  capt_datapath #(.TIMER_W(TIMER_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .capPin(capPin),
    .timerA(timerA), .timerB(timerB), .timerSel(timerSel),
    .flagClr(flagClr), .strb(strb),
    .riseEv(riseEv), .fallEv(fallEv),
    .capValue(capValue), .capFlag(capFlag)
  );
endmodule

// File: rtl/capt_unit_chk.sv
module capt_unit_chk
  import capt_pkg::*;
#(
  parameter int TIMER_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic [3:0]         mode,
  input logic [TIMER_W-1:0] timerA,
  input logic [TIMER_W-1:0] timerB,
  input logic               timerSel,
  input logic               flagClr,
  input logic [TIMER_W-1:0] capValue,
  input logic               capFlag,
  input capStrobes_t        strb
);
  p_no_load_disabled_r2: assert property (@(posedge clk) disable iff (!rstN)
    !isCapture(mode) |-> !strb.loadCap);

  p_load_value_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCap |=> capValue == $past(timerSel ? timerB : timerA));

  p_load_flags_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCap |=> capFlag);

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (capFlag && !flagClr) |=> capFlag);

  p_flag_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !strb.setFlag) |=> !capFlag);

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && strb.setFlag) |=> capFlag);

  p_cap_only_on_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    (capValue != $past(capValue)) |-> $past(strb.loadCap));

  p_enter_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (isCapture(mode) && !isCapture($past(mode)) && !strb.loadCap) |-> !strb.setFlag);
endmodule

bind capt_unit capt_unit_chk #(.TIMER_W(TIMER_W)) u_chk (
  .clk(clk), .rstN(rstN), .mode(mode), .timerA(timerA), .timerB(timerB),
  .timerSel(timerSel), .flagClr(flagClr), .capValue(capValue),
  .capFlag(capFlag), .strb(strb)
);

// File: tb/sim_capt_unit.sv
module sim_capt_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  mode = 4'b0000;
  logic        capPin = 1'b0;
  logic [15:0] timerA = '0;
  logic [15:0] timerB = '0;
  logic        timerSel = 1'b0;
  logic        flagClr = 1'b0;
  logic [15:0] capValue;
  logic        capFlag;

  int checks = 0;
  int errors = 0;
  logic [15:0] expCap = '0;
  bit done = 0;

  always #5 clk = ~clk;

  capt_unit u0 (
    .clk(clk), .rstN(rstN), .mode(mode), .capPin(capPin),
    .timerA(timerA), .timerB(timerB), .timerSel(timerSel),
    .flagClr(flagClr), .capValue(capValue), .capFlag(capFlag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearFlag();
    flagClr = 1'b1; tick(1); flagClr = 1'b0;
  endtask

  task automatic pinTo(input logic v);
    capPin = v; tick(4);
  endtask

  task automatic loadTimers(input logic [15:0] a, input logic sel);
    timerA = a; timerB = ~a; timerSel = sel;
    if (sel) expCap = ~a; else expCap = a;
  endtask

  // rising pulse; fire says whether a capture is expected
  task automatic riseCheck(input string req, input logic fire, input logic [15:0] a, input logic sel);
    logic [15:0] keep;
    keep = expCap;
    loadTimers(a, sel);
    if (!fire) expCap = keep;
    pinTo(1'b1);
    chk({req, " cap"}, capValue, expCap);
    chk({req, " flag"}, capFlag, fire);
    clearFlag();
  endtask

  task automatic fallCheck(input string req, input logic fire, input logic [15:0] a, input logic sel);
    logic [15:0] keep;
    keep = expCap;
    loadTimers(a, sel);
    if (!fire) expCap = keep;
    pinTo(1'b0);
    chk({req, " cap"}, capValue, expCap);
    chk({req, " flag"}, capFlag, fire);
    clearFlag();
  endtask

  initial begin
    tick(3);
    chk("R12 reset cap", capValue, 16'h0);
    chk("R12 reset flag", capFlag, 1'b0);
    rstN = 1'b1;
    tick(2);

    // sweep every mode code (R2 R3 R4 R8 R9 R11)
    for (int m = 0; m < 16; m++) begin
      mode = 4'b0000; tick(2);
      mode = m[3:0]; tick(2);
      chk("R11 no flag on entry", capFlag, 1'b0);
      for (int k = 1; k <= 18; k++) begin
        logic fr, ff;
        fr = (m == 5) || (m == 6 && k % 4 == 0) || (m == 7 && k % 16 == 0);
        ff = (m == 4);
        riseCheck("R8 R2 R3 R4 rise", fr, 16'(16'h1000 + m * 256 + k), k[0]);
        fallCheck("R2 R3 R4 fall", ff, 16'(16'h1080 + m * 256 + k), ~k[0]);
      end
    end

    // R1 latency
    mode = 4'b0000; tick(2); mode = 4'b0101; tick(2);
    timerA = 16'hA1A1; timerSel = 1'b0;
    capPin = 1'b1; tick(2);
    chk("R1 not before edge 3", capValue, expCap);
    tick(1);
    expCap = 16'hA1A1;
    chk("R1 at edge 3", capValue, expCap);
    tick(1); clearFlag(); pinTo(1'b0);

    // R7 overwrite without clearing, R5 sticky
    timerA = 16'h1111; pinTo(1'b1); pinTo(1'b0);
    timerA = 16'h2222; pinTo(1'b1);
    expCap = 16'h2222;
    chk("R7 overwrite", capValue, expCap);
    pinTo(1'b0); tick(10);
    chk("R5 sticky flag", capFlag, 1'b1);

    // R6 set and clear in same cycle
    timerA = 16'h3333;
    capPin = 1'b1; tick(2);
    flagClr = 1'b1; tick(1); flagClr = 1'b0; tick(1);
    expCap = 16'h3333;
    chk("R6 set wins flag", capFlag, 1'b1);
    chk("R6 set wins cap", capValue, expCap);
    clearFlag(); tick(1);
    chk("R5 clear", capFlag, 1'b0);
    pinTo(1'b0);

    // R10 direct ratio change: flag set, no load, early capture
    mode = 4'b0000; tick(2); mode = 4'b0111; tick(2);
    riseCheck("R10 pre1", 1'b0, 16'h4001, 1'b0); fallCheck("R10 pre1f", 1'b0, 16'h4002, 1'b0);
    riseCheck("R10 pre2", 1'b0, 16'h4003, 1'b0); fallCheck("R10 pre2f", 1'b0, 16'h4004, 1'b0);
    mode = 4'b0110; tick(2);
    chk("R10 spurious flag", capFlag, 1'b1);
    chk("R10 no load", capValue, expCap);
    clearFlag();
    riseCheck("R10 early 1", 1'b0, 16'h4005, 1'b1); fallCheck("R10 f", 1'b0, 16'h4006, 1'b0);
    riseCheck("R10 early 2", 1'b1, 16'h4007, 1'b1); fallCheck("R10 f", 1'b0, 16'h4008, 1'b0);

    // R9 clear through off and through a disabled code
    for (int path = 0; path < 2; path++) begin
      mode = 4'b0000; tick(2); mode = 4'b0111; tick(2);
      riseCheck("R9 pre", 1'b0, 16'h5001, 1'b0); fallCheck("R9 pre f", 1'b0, 16'h5002, 1'b0);
      riseCheck("R9 pre", 1'b0, 16'h5003, 1'b0); fallCheck("R9 pre f", 1'b0, 16'h5004, 1'b0);
      mode = (path == 0) ? 4'b0000 : 4'b1010; tick(2);
      mode = 4'b0110; tick(2);
      chk("R11 R9 no flag", capFlag, 1'b0);
      for (int k = 1; k <= 4; k++) begin
        riseCheck("R9 full count", k == 4, 16'(16'h5100 + path * 16 + k), 1'b0);
        fallCheck("R9 f", 1'b0, 16'(16'h5180 + k), 1'b0);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule